// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial input line into whole characters. It takes a free-running oversampling strobe from outside, at sixteen strobes per bit time, and watches an idle-high line for a falling edge. When it finds one, it confirms the start bit, then shifts in five to eight data bits with the least significant bit first. An optional parity bit follows the data. The character is complete at the first stop bit. Each finished character is placed into a one-entry holding buffer together with three status flags. The framing and parity flags describe that character. The overrun flag records that a later character was lost while this one was still waiting.

The consumer drains the buffer through a valid/ready pair. `rx_valid` is the receive-complete indication: it stays high while an unread character waits. One character moves out on every clock edge at which `rx_valid` and `rx_ready` are both high. The consumer may hold `rx_ready` low for as long as it likes. In that case the held character and its flags stay frozen, and the receiver keeps listening to the line. Any character that finishes while the buffer is still occupied is dropped and raises the overrun flag. The frame-size and parity controls are plain level inputs and must be set up before a frame begins.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, `rx_valid`, `rx_frame_err`, `rx_parity_err` and `rx_overrun` are all 0.
- R2: A start bit counts only if the synchronised line is still low at oversample point 8 of 16, counted from the strobe that first saw it low. A low pulse shorter than that returns the receiver to idle and delivers no character.
- R3: Each data, parity and stop bit takes the majority value of oversample points 7, 8 and 9 of its bit. A disturbance that hits only one of those points does not change the received value.
- R4: `width_sel` selects the number of data bits as 5 + `width_sel` (0 gives 5 bits, 3 gives 8 bits). Data arrives least significant bit first, and `rx_data` bits above the selected width read as 0.
- R5: When `parity_en` is 1, one parity bit follows the last data bit. With `parity_odd` = 0 the data bits plus the parity bit must hold an even number of ones; with `parity_odd` = 1 they must hold an odd number. A mismatch sets `rx_parity_err` for that character. When `parity_en` is 0 the parity flag is always 0.
- R6: Only the first stop bit is sampled. If it reads 0, the character is still delivered with `rx_frame_err` = 1. The receiver is ready for a new start bit directly after that stop bit, so a frame with a single stop bit followed at once by the next start bit is received correctly.
- R7: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid`, `rx_data` and all three flags hold their values. A transfer takes place on a clock edge where both are 1. After such a transfer `rx_valid` is 0 in the next cycle, unless a new character completed on that same edge.
- R8: If a character completes while the buffer holds an unread character that is not being taken on that edge, the held character is kept, the new one is discarded and `rx_overrun` becomes 1. The transfer out of the buffer clears `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling strobe, one cycle wide, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| width_sel | input | 2 | Data bits per frame minus five |
| parity_en | input | 1 | 1: a parity bit follows the data |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_ready | input | 1 | Consumer accepts the buffered character |
| rx_valid | output | 1 | An unread character is in the buffer |
| rx_data | output | 8 | Buffered character, unused upper bits zero |
| rx_frame_err | output | 1 | First stop bit of the buffered character read 0 |
| rx_parity_err | output | 1 | Parity of the buffered character did not match |
| rx_overrun | output | 1 | A later character was lost while this one waited |

## Verification
Suppose the bit sequencer loses track of its oversample position or bit count. Every later character then comes out with its bits shifted, or with a wrong framing flag. This is visible on `rx_data` about half a bit time after the stop bit should have been sampled. A sequencer that stays out of idle, for example after a rejected start pulse or after a framing error, shows up as a spurious or missing `rx_valid` within one frame time. A corrupted buffer or overrun state breaks the hold-while-not-ready rule at once. It also shows up at the next transfer as a wrong value or a wrong overrun flag.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DW       = 8;
  localparam int SRX_MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } srx_state_e;

  typedef struct packed {
    logic [SRX_DW-1:0] data;
    logic              ferr;
    logic              perr;
  } srx_char_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (!rst_n) ff <= '1;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic [1:0] width_sel,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       push,
  output srx_char_t  push_char
);
  localparam int SW = $clog2(OSR);
  localparam int CW = $clog2(SRX_DW);
  localparam logic [SW-1:0] P_MID  = SW'(OSR / 2);
  localparam logic [SW-1:0] P_LO   = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] P_HI   = SW'(OSR / 2 + 1);
  localparam logic [SW-1:0] P_LAST = SW'(OSR - 1);

  srx_state_e        state;
  logic [SW-1:0]     sub, idx;
  logic [1:0]        votes;
  logic              bitv;
  logic [SRX_DW-1:0] shreg;
  logic [CW-1:0]     cnt, nlast, align;
  logic              par_acc, par_bad;

  // Sample index of the strobe being taken now; wraps at OSR.
  assign idx   = sub + 1'b1;
  // Majority of points 7, 8 and 9: two stored votes plus the live sample.
  assign bitv  = (votes[1] & votes[0]) | (votes[1] & rx_s) | (votes[0] & rx_s);
  assign nlast = CW'(width_sel) + CW'(SRX_MIN_BITS - 1);
  assign align = CW'(SRX_DW - 1) - nlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sub       <= '0;
      votes     <= '0;
      shreg     <= '0;
      cnt       <= '0;
      par_acc   <= 1'b0;
      par_bad   <= 1'b0;
      push      <= 1'b0;
      push_char <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (!rx_s) begin
            state <= ST_START;
            sub   <= '0;
          end
        end else begin
          sub <= idx;
          if (idx == P_LO || idx == P_MID) votes <= {votes[0], rx_s};
          case (state)
            ST_START: begin
              if (idx == P_MID && rx_s) begin
                state <= ST_IDLE;
              end else if (idx == P_LAST) begin
                state   <= ST_DATA;
                cnt     <= '0;
                par_acc <= 1'b0;
                par_bad <= 1'b0;
              end
            end
            ST_DATA: begin
              if (idx == P_HI) begin
                shreg   <= {bitv, shreg[SRX_DW-1:1]};
                par_acc <= par_acc ^ bitv;
              end
              if (idx == P_LAST) begin
                cnt <= cnt + 1'b1;
                if (cnt == nlast) state <= par_en ? ST_PAR : ST_STOP;
              end
            end
            ST_PAR: begin
              if (idx == P_HI)   par_bad <= bitv ^ par_acc ^ par_odd;
              if (idx == P_LAST) state <= ST_STOP;
            end
            ST_STOP: begin
              if (idx == P_HI) begin
                push           <= 1'b1;
                push_char.data <= shreg >> align;
                push_char.ferr <= ~bitv;
                push_char.perr <= par_en & par_bad;
                state          <= ST_IDLE;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R2: a line found high at the mid point of the start bit drops the frame
  p_start_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state == ST_START && idx == P_MID && rx_s) |=> (state == ST_IDLE));

  // R6: each character is announced for exactly one cycle
  p_push_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

  // R6: a character only ever leaves from the stop-bit phase
  p_push_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ($past(state) == ST_STOP));
endmodule

// File: rtl/srx_holdbuf.sv
module srx_holdbuf
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  srx_char_t         push_char,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [SRX_DW-1:0] out_data,
  output logic              out_ferr,
  output logic              out_perr,
  output logic              out_ovr
);
  srx_char_t held;
  logic      pop;

  assign pop = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= '0;
      out_valid <= 1'b0;
      out_ovr   <= 1'b0;
    end else if (push) begin
      if (!out_valid || pop) begin
        held      <= push_char;
        out_valid <= 1'b1;
        out_ovr   <= 1'b0;
      end else begin
        out_ovr <= 1'b1;
      end
    end else if (pop) begin
      out_valid <= 1'b0;
      out_ovr   <= 1'b0;
    end
  end

  assign out_data = held.data;
  assign out_ferr = held.ferr;
  assign out_perr = held.perr;

  // R7: back-pressure freezes the buffered character
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_ferr) && $stable(out_perr)));

  // R7: a transfer with nothing arriving empties the buffer
  p_pop_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> !out_valid);

  // R8: overrun can only appear while a character is being held
  p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ovr) |-> $past(out_valid));
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic [1:0]        width_sel,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [SRX_DW-1:0] rx_data,
  output logic              rx_frame_err,
  output logic              rx_parity_err,
  output logic              rx_overrun
);
  logic      rx_s;
  logic      push;
  srx_char_t push_char;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_in),
    .q     (rx_s)
  );

  srx_framer #(.OSR(OVERSAMPLE)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .rx_s      (rx_s),
    .width_sel (width_sel),
    .par_en    (parity_en),
    .par_odd   (parity_odd),
    .push      (push),
    .push_char (push_char)
  );

  srx_holdbuf u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_char (push_char),
    .out_ready (rx_ready),
    .out_valid (rx_valid),
    .out_data  (rx_data),
    .out_ferr  (rx_frame_err),
    .out_perr  (rx_parity_err),
    .out_ovr   (rx_overrun)
  );
endmodule

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] width_sel = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_frame_err, rx_parity_err, rx_overrun;

  int vectors = 0;
  int fails = 0;
  int tdiv = 0;

  serial_rx_top dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .width_sel(width_sel), .parity_en(parity_en), .parity_odd(parity_odd),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .rx_overrun(rx_overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    for (int c = 0; c < BIT_CLKS; c++) begin
      @(negedge clk);
      rx_in = (glitch && c >= 32 && c < 36) ? ~v : v;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input bit flip_par,
                            input logic stop_v, input int glitch_bit);
    logic [7:0] m;
    m = 8'hFF >> (8 - n);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i], glitch_bit == i);
    if (parity_en) drive_bit((^(d & m)) ^ parity_odd ^ flip_par, 1'b0);
    drive_bit(stop_v, 1'b0);
    @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (rx_valid) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pop_one();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic expect_char(input string req, input logic [7:0] d, input logic fe,
                             input logic pe, input logic ov);
    bit ok;
    wait_valid(ok);
    chk({req, " valid"}, 32'(ok), 32'd1);
    chk({req, " data"}, 32'(rx_data), 32'(d));
    chk({req, " frame_err"}, 32'(rx_frame_err), 32'(fe));
    chk({req, " parity_err"}, 32'(rx_parity_err), 32'(pe));
    chk({req, " overrun"}, 32'(rx_overrun), 32'(ov));
    pop_one();
    chk({req, " drained"}, 32'(rx_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(rx_valid), 32'd0);
    chk("R1 frame_err", 32'(rx_frame_err), 32'd0);
    chk("R1 parity_err", 32'(rx_parity_err), 32'd0);
    chk("R1 overrun", 32'(rx_overrun), 32'd0);
  endtask

  task automatic t_eight_bit();
    width_sel = 2'd3; parity_en = 1'b0;
    send_frame(8'hA5, 8, 1'b0, 1'b1, -1);
    expect_char("R4 8bit A5", 8'hA5, 1'b0, 1'b0, 1'b0);
    send_frame(8'h3C, 8, 1'b0, 1'b1, -1);
    expect_char("R4 8bit 3C", 8'h3C, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_short_frames();
    for (int w = 0; w < 3; w++) begin
      width_sel = 2'(w);
      send_frame(8'hFF, 5 + w, 1'b0, 1'b1, -1);
      expect_char("R4 short all-ones", 8'hFF >> (3 - w), 1'b0, 1'b0, 1'b0);
    end
    width_sel = 2'd0;
    send_frame(8'h15, 5, 1'b0, 1'b1, -1);
    expect_char("R4 5bit 15", 8'h15, 1'b0, 1'b0, 1'b0);
    width_sel = 2'd3;
  endtask

  task automatic t_parity();
    parity_en = 1'b1; parity_odd = 1'b0;
    send_frame(8'h37, 8, 1'b0, 1'b1, -1);
    expect_char("R5 even ok", 8'h37, 1'b0, 1'b0, 1'b0);
    send_frame(8'h37, 8, 1'b1, 1'b1, -1);
    expect_char("R5 even bad", 8'h37, 1'b0, 1'b1, 1'b0);
    parity_odd = 1'b1;
    width_sel  = 2'd1;
    send_frame(8'h2B, 6, 1'b0, 1'b1, -1);
    expect_char("R5 odd ok", 8'h2B, 1'b0, 1'b0, 1'b0);
    send_frame(8'h2B, 6, 1'b1, 1'b1, -1);
    expect_char("R5 odd bad", 8'h2B, 1'b0, 1'b1, 1'b0);
    parity_en = 1'b0; parity_odd = 1'b0; width_sel = 2'd3;
  endtask

  task automatic t_framing();
    send_frame(8'h81, 8, 1'b0, 1'b0, -1);
    expect_char("R6 stop low", 8'h81, 1'b1, 1'b0, 1'b0);
    repeat (12 * BIT_CLKS) @(negedge clk);
    chk("R6 no char after break", 32'(rx_valid), 32'd0);
    send_frame(8'h66, 8, 1'b0, 1'b1, -1);
    expect_char("R6 recovers", 8'h66, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_start_glitch();
    @(negedge clk);
    rx_in = 1'b0;
    repeat (5 * TICK_DIV) @(negedge clk);
    rx_in = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    chk("R2 short low rejected", 32'(rx_valid), 32'd0);
    send_frame(8'h5E, 8, 1'b0, 1'b1, -1);
    expect_char("R2 next frame", 8'h5E, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_majority();
    send_frame(8'h00, 8, 1'b0, 1'b1, 3);
    expect_char("R3 glitch high", 8'h00, 1'b0, 1'b0, 1'b0);
    send_frame(8'hFF, 8, 1'b0, 1'b1, 0);
    expect_char("R3 glitch low", 8'hFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overrun();
    bit ok;
    send_frame(8'h11, 8, 1'b0, 1'b1, -1);
    repeat (100) @(negedge clk);
    chk("R7 held data", 32'(rx_data), 32'h11);
    chk("R7 held valid", 32'(rx_valid), 32'd1);
    send_frame(8'h22, 8, 1'b0, 1'b1, -1);
    wait_valid(ok);
    chk("R8 keeps first", 32'(rx_data), 32'h11);
    chk("R8 overrun set", 32'(rx_overrun), 32'd1);
    pop_one();
    chk("R8 overrun cleared", 32'(rx_overrun), 32'd0);
    chk("R8 new char dropped", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_back_to_back();
    fork
      begin
        send_frame(8'h5A, 8, 1'b0, 1'b1, -1);
        send_frame(8'hC3, 8, 1'b0, 1'b1, -1);
      end
      begin
        expect_char("R6 first of pair", 8'h5A, 1'b0, 1'b0, 1'b0);
      end
    join
    expect_char("R6 second of pair", 8'hC3, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_eight_bit();
    t_short_frames();
    t_parity();
    t_framing();
    t_start_glitch();
    t_majority();
    t_overrun();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule